// File: doc/BRIEF.md
# Dual-Channel DMA Control Register File

This block holds the software-visible control state of a two-channel bus-master DMA engine for a disk interface. Each channel has an eight-byte window made of two 32-bit words. The first word is a control word: its four byte lanes carry the command byte, a mode byte that both channels share, the status byte and the channel's drive-timing byte. The second word holds the channel's descriptor table base address. The block does not move data or walk descriptors. It only keeps register state and gives the engine start and stop strobes, a direction bit, timing bytes and descriptor bases.

The host reaches the block through a simple synchronous port. A two-bit word index picks the word: bit 1 selects the channel and bit 0 selects the descriptor word over the control word. Byte enables pick lanes, so byte offset `4*index + lane` names each byte, and lane `k` of the control word is register `k`. A read strobe returns the whole selected word one cycle later, with a valid flag.

Each channel's interrupt level is copied into a pending flag in the shared mode byte. Each channel also has a block mask in that byte. A single interrupt output combines the pending-and-unblocked terms of both channels.

Two small state machines set the timing. The host port machine has the states HOST_IDLE and HOST_RESP. A read strobe takes it to HOST_RESP, which presents the data; with no strobe it returns to HOST_IDLE. Each channel has a run machine with the states RUN_IDLE and RUN_ACTIVE. The START transition happens when a command write sets bit 0 while the channel is idle, and it emits a one-cycle start strobe. The STOP transition happens when a command write clears bit 0 while the channel is active, and it emits a one-cycle stop strobe.

Top module: `dmareg_top`

## Requirements
- R1: After reset every register byte, pending flag and block mask is zero, `irq_out` is low, `host_rvalid` is low and no strobe is asserted.
- R2: A read strobe with word index `i` makes `host_rvalid` high on the following cycle, with `host_rdata` holding word `i` as it stood at the strobe edge. `host_rvalid` is low in every cycle that does not follow a read strobe.
- R3: The command byte (control lane 0) stores bit 0 (run) and bit 3 (direction). Its other bits read as 0, and `dir_out[c]` equals the stored bit 3.
- R4: A command write that changes run from 0 to 1 pulses `start_pulse[c]` for exactly one cycle, starting the cycle after the write. A change from 1 to 0 pulses `stop_pulse[c]` the same way. A write that leaves run unchanged produces no pulse.
- R5: A write to lane 1 of either channel's control word updates only mode bit 4 (block channel 0) and bit 5 (block channel 1). Mode bits 7, 6, 1 and 0 always read as 0.
- R6: Mode bit 2 and bit 3 hold the `irq_in[0]` and `irq_in[1]` levels sampled at the previous clock edge, and mode writes do not touch them.
- R7: `irq_out` = (mode bit 2 AND NOT bit 4) OR (mode bit 3 AND NOT bit 5), evaluated on the current register contents.
- R8: A status write (lane 2) loads status bits 6 and 5 from the data. Status bits 7, 4 and 3 always read as 0.
- R9: Status bit 1 is set by `eng_err[c]` and status bit 2 by `eng_intr[c]`. A status write clears each of these bits where the data bit is 1 and keeps it where the data bit is 0. A set in the same cycle as a clear wins.
- R10: Status bit 0 reads the engine's `eng_active[c]` level at the read edge and cannot be written.
- R11: The timing byte (lane 3) is fully read/write per channel, reads back through its own channel's window, and appears on `timing_out[8c+7:8c]`.
- R12: The descriptor word takes each byte lane whose enable is set. Bits 1:0 always read as 0, and the value appears on `desc_base[32c+31:32c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_widx | input | 2 | Word index: bit 1 channel, bit 0 descriptor word |
| host_wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| host_be | input | 4 | Byte lane enables for writes |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| irq_in | input | 2 | Interrupt level from each channel |
| eng_active | input | 2 | Engine active state per channel (status bit 0) |
| eng_err | input | 2 | Sets status bit 1 of a channel |
| eng_intr | input | 2 | Sets status bit 2 of a channel |
| irq_out | output | 1 | Combined interrupt output |
| start_pulse | output | 2 | One-cycle start strobe per channel |
| stop_pulse | output | 2 | One-cycle stop strobe per channel |
| dir_out | output | 2 | Transfer direction per channel |
| timing_out | output | 16 | Timing byte per channel |
| desc_base | output | 64 | Descriptor base per channel |

## Verification
Assertions check, on every cycle, the invariants that hold from one cycle to the next. A start strobe never lasts two cycles. Block masks never move without a mode write. The interrupt output stays low after a cycle with both levels low. A status write that clears bit 1 clears it unless the engine sets it in that cycle. A valid read always follows a strobe, and descriptor reads return zero low bits. Only the bench scenarios can show the merged mode byte seen from both windows, the per-lane descriptor merge, set-over-clear ordering in status, and the cycle on which each strobe appears. The bench compares every read and output against a model after random mixes of writes, reads and changes in interrupt level.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int NCH      = 2;
    localparam int DW       = 32;
    localparam int NB       = DW / 8;
    localparam int WIDX_W   = 2;

    localparam int LANE_CMD  = 0;
    localparam int LANE_MODE = 1;
    localparam int LANE_STAT = 2;
    localparam int LANE_TIM  = 3;

    localparam int CMD_RUN  = 0;
    localparam int CMD_DIR  = 3;

    localparam int MODE_PEND_LO = 2;
    localparam int MODE_BLK_LO  = 4;

    typedef enum logic [0:0] {
        HOST_IDLE = 1'b0,
        HOST_RESP = 1'b1
    } host_state_t;

    typedef enum logic [0:0] {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_t;

endpackage

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic          desc_we,
    input  logic [NB-1:0] be,
    input  logic [DW-1:0] wdata,
    input  logic          eng_active,
    input  logic          eng_err,
    input  logic          eng_intr,
    output logic [7:0]    cmd_byte,
    output logic [7:0]    stat_byte,
    output logic [7:0]    tim_byte,
    output logic [DW-1:0] desc_q,
    output logic          start_pulse,
    output logic          stop_pulse,
    output logic          dir
);

    logic [7:0] cmd_wb;
    logic [7:0] stat_wb;
    logic [7:0] tim_wb;
    logic       cmd_we;
    logic       stat_we;
    logic       tim_we;

    assign cmd_wb  = wdata[8*LANE_CMD  +: 8];
    assign stat_wb = wdata[8*LANE_STAT +: 8];
    assign tim_wb  = wdata[8*LANE_TIM  +: 8];
    assign cmd_we  = ctrl_we && be[LANE_CMD];
    assign stat_we = ctrl_we && be[LANE_STAT];
    assign tim_we  = ctrl_we && be[LANE_TIM];

    // run state machine
    run_state_t run_q;
    run_state_t run_d;

    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_IDLE: begin
                if (cmd_we && cmd_wb[CMD_RUN]) begin
                    run_d = RUN_ACTIVE;
                end
            end
            RUN_ACTIVE: begin
                if (cmd_we && !cmd_wb[CMD_RUN]) begin
                    run_d = RUN_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= RUN_IDLE;
        end else begin
            run_q <= run_d;
        end
    end

    // outputs of the run machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            dir         <= 1'b0;
        end else begin
            start_pulse <= (run_q == RUN_IDLE)   && (run_d == RUN_ACTIVE);
            stop_pulse  <= (run_q == RUN_ACTIVE) && (run_d == RUN_IDLE);
            if (cmd_we) begin
                dir <= cmd_wb[CMD_DIR];
            end
        end
    end

    assign cmd_byte = {4'b0000, dir, 2'b00, (run_q == RUN_ACTIVE)};

    // status: bits 6:5 plain, bits 2:1 sticky flags, bit 0 live
    logic [1:0] s65_q;
    logic [1:0] flg_q;
    logic [1:0] flg_d;

    always_comb begin
        flg_d = flg_q;
        if (stat_we) begin
            flg_d = flg_q & ~stat_wb[2:1];
        end
        flg_d = flg_d | {eng_intr, eng_err};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s65_q <= 2'b00;
            flg_q <= 2'b00;
        end else begin
            flg_q <= flg_d;
            if (stat_we) begin
                s65_q <= stat_wb[6:5];
            end
        end
    end

    assign stat_byte = {1'b0, s65_q, 2'b00, flg_q, eng_active};

    // timing byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_byte <= 8'h00;
        end else if (tim_we) begin
            tim_byte <= tim_wb;
        end
    end

    // descriptor base, one register per byte lane
    for (genvar k = 0; k < NB; k++) begin : g_desc_lane
        localparam logic [7:0] KEEP = (k == 0) ? 8'hFC : 8'hFF;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                desc_q[8*k +: 8] <= 8'h00;
            end else if (desc_we && be[k]) begin
                desc_q[8*k +: 8] <= wdata[8*k +: 8] & KEEP;
            end
        end
    end

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && stat_wb[1] && !eng_err) |=> !stat_byte[1]);

endmodule

// File: rtl/dmareg_mode.sv
module dmareg_mode
    import dmareg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_we,
    input  logic [NCH-1:0] blk_wdata,
    input  logic [NCH-1:0] irq_in,
    output logic [7:0]     mode_byte,
    output logic           irq_out
);

    logic [NCH-1:0] blk_q;
    logic [NCH-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= '0;
            pend_q <= '0;
        end else begin
            pend_q <= irq_in;
            if (mode_we) begin
                blk_q <= blk_wdata;
            end
        end
    end

    always_comb begin
        mode_byte = 8'h00;
        mode_byte[MODE_PEND_LO +: NCH] = pend_q;
        mode_byte[MODE_BLK_LO  +: NCH] = blk_q;
    end

    assign irq_out = |(pend_q & ~blk_q);

    // R5
    blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(blk_q));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_in) == '0) |-> !irq_out);

endmodule

// File: rtl/dmareg_host.sv
module dmareg_host
    import dmareg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic [DW-1:0] read_word,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    host_state_t st_q;
    host_state_t st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HOST_IDLE: st_d = rd ? HOST_RESP : HOST_IDLE;
            HOST_RESP: st_d = rd ? HOST_RESP : HOST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= HOST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= read_word;
        end
    end

    assign rvalid = (st_q == HOST_RESP);

    // R2
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd));

endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
    import dmareg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDX_W-1:0] host_widx,
    input  logic [DW-1:0]     host_wdata,
    input  logic [NB-1:0]     host_be,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [DW-1:0]     host_rdata,
    output logic              host_rvalid,
    input  logic [NCH-1:0]    irq_in,
    input  logic [NCH-1:0]    eng_active,
    input  logic [NCH-1:0]    eng_err,
    input  logic [NCH-1:0]    eng_intr,
    output logic              irq_out,
    output logic [NCH-1:0]    start_pulse,
    output logic [NCH-1:0]    stop_pulse,
    output logic [NCH-1:0]    dir_out,
    output logic [NCH*8-1:0]  timing_out,
    output logic [NCH*DW-1:0] desc_base
);

    logic           sel_ch;
    logic           sel_desc;
    logic [7:0]     mode_byte;
    logic           mode_we;
    logic [7:0]     cmd_b  [NCH];
    logic [7:0]     stat_b [NCH];
    logic [7:0]     tim_b  [NCH];
    logic [DW-1:0]  desc_w [NCH];
    logic [DW-1:0]  read_word;

    assign sel_ch   = host_widx[1];
    assign sel_desc = host_widx[0];
    assign mode_we  = host_wr && !sel_desc && host_be[LANE_MODE];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dmareg_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctrl_we     (host_wr && !sel_desc && (sel_ch == c[0])),
            .desc_we     (host_wr &&  sel_desc && (sel_ch == c[0])),
            .be          (host_be),
            .wdata       (host_wdata),
            .eng_active  (eng_active[c]),
            .eng_err     (eng_err[c]),
            .eng_intr    (eng_intr[c]),
            .cmd_byte    (cmd_b[c]),
            .stat_byte   (stat_b[c]),
            .tim_byte    (tim_b[c]),
            .desc_q      (desc_w[c]),
            .start_pulse (start_pulse[c]),
            .stop_pulse  (stop_pulse[c]),
            .dir         (dir_out[c])
        );
        assign timing_out[8*c +: 8]  = tim_b[c];
        assign desc_base[DW*c +: DW] = desc_w[c];
    end

    dmareg_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_we   (mode_we),
        .blk_wdata (host_wdata[8*LANE_MODE + MODE_BLK_LO +: NCH]),
        .irq_in    (irq_in),
        .mode_byte (mode_byte),
        .irq_out   (irq_out)
    );

    always_comb begin
        if (sel_desc) begin
            read_word = desc_w[sel_ch];
        end else begin
            read_word = '0;
            read_word[8*LANE_CMD  +: 8] = cmd_b[sel_ch];
            read_word[8*LANE_MODE +: 8] = mode_byte;
            read_word[8*LANE_STAT +: 8] = stat_b[sel_ch];
            read_word[8*LANE_TIM  +: 8] = tim_b[sel_ch];
        end
    end

    dmareg_host u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (host_rd),
        .read_word (read_word),
        .rdata     (host_rdata),
        .rvalid    (host_rvalid)
    );

    // R12
    desc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && $past(host_widx[0])) |-> (host_rdata[1:0] == 2'b00));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse & stop_pulse) == '0);

endmodule

// File: tb/tb_dmareg_top.sv
`timescale 1ns/1ps
module tb_dmareg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_widx = '0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_be = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic [1:0]  irq_in = '0;
    logic [1:0]  eng_active = '0;
    logic [1:0]  eng_err = '0;
    logic [1:0]  eng_intr = '0;
    logic        irq_out;
    logic [1:0]  start_pulse, stop_pulse, dir_out;
    logic [15:0] timing_out;
    logic [63:0] desc_base;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dmareg_top dut (
        .clk(clk), .rst_n(rst_n), .host_widx(host_widx), .host_wdata(host_wdata),
        .host_be(host_be), .host_wr(host_wr), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .irq_in(irq_in),
        .eng_active(eng_active), .eng_err(eng_err), .eng_intr(eng_intr),
        .irq_out(irq_out), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .dir_out(dir_out), .timing_out(timing_out), .desc_base(desc_base)
    );

    // model state
    logic [1:0]  m_run, m_dir, m_blk, m_pend;
    logic [1:0]  m_s65 [2];
    logic [1:0]  m_flg [2];
    logic [7:0]  m_tim [2];
    logic [31:0] m_desc [2];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] f_mode();
        return {2'b00, m_blk, m_pend, 2'b00};
    endfunction

    function automatic logic [7:0] f_stat(input int c, input logic a);
        return {1'b0, m_s65[c], 2'b00, m_flg[c], a};
    endfunction

    function automatic logic f_irq();
        return |(m_pend & ~m_blk);
    endfunction

    task automatic model_reset();
        m_run = '0; m_dir = '0; m_blk = '0; m_pend = '0;
        for (int c = 0; c < 2; c++) begin
            m_s65[c] = '0; m_flg[c] = '0; m_tim[c] = '0; m_desc[c] = '0;
        end
    endtask

    // one cycle: drive at negedge, model the edge, check at next negedge
    task automatic step(input bit wr, input bit rd, input logic [1:0] widx,
                        input logic [3:0] be, input logic [31:0] wd,
                        input logic [1:0] irq, input logic [1:0] err,
                        input logic [1:0] intr, input logic [1:0] act);
        int c;
        logic [1:0] xs, xp;
        logic [7:0] e_cmd, e_mode, e_stat, e_tim;
        logic [31:0] e_desc;
        c = int'(widx[1]);
        host_wr = wr; host_rd = rd; host_widx = widx; host_be = be; host_wdata = wd;
        irq_in = irq; eng_err = err; eng_intr = intr; eng_active = act;
        e_cmd  = {4'b0, m_dir[c], 2'b00, m_run[c]};
        e_mode = f_mode();
        e_stat = f_stat(c, act[c]);
        e_tim  = m_tim[c];
        e_desc = m_desc[c];
        xs = '0; xp = '0;
        m_pend = irq;
        if (wr) begin
            if (widx[0]) begin
                for (int k = 0; k < 4; k++)
                    if (be[k]) m_desc[c][8*k +: 8] = wd[8*k +: 8];
                m_desc[c][1:0] = 2'b00;
            end else begin
                if (be[0]) begin
                    if (!m_run[c] && wd[0]) xs[c] = 1'b1;
                    if (m_run[c] && !wd[0]) xp[c] = 1'b1;
                    m_run[c] = wd[0];
                    m_dir[c] = wd[3];
                end
                if (be[1]) m_blk = wd[13:12];
                if (be[2]) begin
                    m_s65[c] = wd[22:21];
                    m_flg[c] = m_flg[c] & ~wd[18:17];
                end
                if (be[3]) m_tim[c] = wd[31:24];
            end
        end
        for (int i = 0; i < 2; i++) m_flg[i] = m_flg[i] | {intr[i], err[i]};
        @(posedge clk);
        @(negedge clk);
        chk("R2 rvalid", 64'(host_rvalid), 64'(rd));
        if (rd) begin
            if (widx[0]) begin
                chk("R12 desc read", 64'(host_rdata), 64'(e_desc));
            end else begin
                chk("R3 cmd byte", 64'(host_rdata[7:0]), 64'(e_cmd));
                chk("R5 mode mask bits", 64'({host_rdata[15:12], host_rdata[9:8]}),
                    64'({e_mode[7:4], e_mode[1:0]}));
                chk("R6 mode pending bits", 64'(host_rdata[11:10]), 64'(e_mode[3:2]));
                chk("R8 status plain bits", 64'(host_rdata[23:19]), 64'(e_stat[7:3]));
                chk("R9 status flags", 64'(host_rdata[18:17]), 64'(e_stat[2:1]));
                chk("R10 status active", 64'(host_rdata[16]), 64'(e_stat[0]));
                chk("R11 timing read", 64'(host_rdata[31:24]), 64'(e_tim));
            end
        end
        chk("R7 irq_out", 64'(irq_out), 64'(f_irq()));
        chk("R4 start_pulse", 64'(start_pulse), 64'(xs));
        chk("R4 stop_pulse", 64'(stop_pulse), 64'(xp));
        chk("R3 dir_out", 64'(dir_out), 64'(m_dir));
        chk("R11 timing_out", 64'(timing_out), 64'({m_tim[1], m_tim[0]}));
        chk("R12 desc_base", desc_base, {m_desc[1], m_desc[0]});
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic wr_step(input logic [1:0] widx, input logic [3:0] be, input logic [31:0] wd,
                           input logic [1:0] irq);
        step(1'b1, 1'b0, widx, be, wd, irq, 2'b00, 2'b00, 2'b00);
    endtask

    task automatic rd_step(input logic [1:0] widx, input logic [1:0] irq, input logic [1:0] act);
        step(1'b0, 1'b1, widx, 4'h0, 32'h0, irq, 2'b00, 2'b00, act);
    endtask

    initial begin
        void'($urandom(32'd7321));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq_out", 64'(irq_out), 64'd0);
        chk("R1 rvalid", 64'(host_rvalid), 64'd0);
        chk("R1 strobes", 64'({start_pulse, stop_pulse}), 64'd0);
        chk("R1 timing/desc", 64'(timing_out) | desc_base, 64'd0);
        for (int w = 0; w < 4; w++) begin
            step(1'b0, 1'b1, 2'(w), 4'h0, 32'h0, 2'b00, 2'b00, 2'b00, 2'b00);
            chk("R1 word zero", 64'(host_rdata), 64'd0);
        end

        // mode merge and masks, R5 R6 R7
        wr_step(2'b00, 4'h2, 32'h0000_FF00, 2'b11);   // only bits 5:4 stick
        rd_step(2'b10, 2'b11, 2'b00);                 // seen from ch1 window
        wr_step(2'b10, 4'h2, 32'h0000_1000, 2'b11);   // block ch0, ch1 open
        rd_step(2'b00, 2'b01, 2'b00);
        step(1'b0, 1'b0, 2'b00, 4'h0, 32'h0, 2'b00, 2'b00, 2'b00, 2'b00);
        step(1'b0, 1'b0, 2'b00, 4'h0, 32'h0, 2'b10, 2'b00, 2'b00, 2'b00);

        // command strobes, R4
        wr_step(2'b00, 4'h1, 32'h0000_0009, 2'b00);
        step(1'b0, 1'b0, 2'b00, 4'h0, 32'h0, 2'b00, 2'b00, 2'b00, 2'b00);
        wr_step(2'b00, 4'h1, 32'h0000_0001, 2'b00);  // no change, no strobe
        wr_step(2'b00, 4'h1, 32'h0000_0000, 2'b00);

        // status flags: set, clear, set-over-clear, R8 R9 R10
        step(1'b0, 1'b0, 2'b00, 4'h0, 32'h0, 2'b00, 2'b11, 2'b11, 2'b00);
        rd_step(2'b10, 2'b00, 2'b10);
        step(1'b1, 1'b0, 2'b10, 4'h4, 32'h00FF_0000, 2'b00, 2'b10, 2'b00, 2'b00);
        rd_step(2'b10, 2'b00, 2'b11);
        wr_step(2'b00, 4'h4, 32'h0002_0000, 2'b00);
        rd_step(2'b00, 2'b00, 2'b01);

        // descriptor lanes, R12
        wr_step(2'b01, 4'hF, 32'hDEAD_BEEF, 2'b00);
        wr_step(2'b01, 4'h4, 32'h0055_0000, 2'b00);
        rd_step(2'b01, 2'b00, 2'b00);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [1:0] ni, ne, nn, na;
            op = int'($urandom_range(0, 99));
            ni = ($urandom_range(0, 3) == 0) ? 2'($urandom) : irq_in;
            na = ($urandom_range(0, 7) == 0) ? 2'($urandom) : eng_active;
            ne = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00;
            nn = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00;
            step(op < 45, (op >= 45) && (op < 85), 2'($urandom), 4'($urandom),
                 $urandom, ni, ne, nn, na);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule